// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block provides a bank of general-purpose I/O lines, 32 by default, behind a small memory-mapped register interface. Every line can be set as an input or an output. Every input can also act as a level-sensitive interrupt source, and its active polarity is set per line. Registers sit in two windows that a single select bit chooses between. The port window holds direction, data, polarity and status. The interrupt window holds the pending view and the mask.

Input pins pass through a two-stage synchroniser before any logic uses them. While a synchronised line sits at its active level, its status bit is set on every clock. Software clears a status bit by writing 0 to it. The status bits that the mask lets through are combined into a single registered interrupt toward a parent controller. A typical handler masks everything by writing all ones to the mask, then clears one line by writing the complement of that line's one-hot value.

The request interface is single-cycle. A write takes effect at the clock edge where `req_valid` and `req_write` are both high. Read data is combinational from the registers while `req_valid` is high and `req_write` is low, and it reads zero otherwise.

Top module: `pio_lvlint_ctrl`

## Requirements
- R1: After reset the mask is all ones, direction is all inputs (0), the output latch is 0, polarity is all zeros, status is 0 and `irq_out` is low. The synchroniser stages reset to all ones, so a high pin reads back as 1 straight after reset.
- R2: The direction register sits at port-window (`req_win`=0) offset 0x04. Bit value 1 makes the line an output. `pin_oe` equals the direction register and `pin_out` equals the output latch.
- R3: The data register sits at port-window offset 0x08. A write loads the output latch. A read returns the latch bit for output lines and the synchronised pin for input lines. A pin change becomes visible in the read after two rising edges.
- R4: The polarity register sits at port-window offset 0x0C. A bit value of 1 makes the line active-high and 0 makes it active-low. A line held at its active level sets its status bit at the third rising edge after the pin change, and the bit stays set after the level goes away.
- R5: The status register sits at port-window offset 0x10. A write clears each bit written as 0 and leaves each bit written as 1 unchanged. A line that is active in the same cycle keeps its bit set, so setting wins over clearing.
- R6: The mask register sits at interrupt-window (`req_win`=1) offset 0x08. A mask bit of 1 blocks its line and 0 passes it. Writing all ones blocks every line.
- R7: The pending register sits at interrupt-window offset 0x00. It reads the status bits and ignores writes.
- R8: `irq_out` is registered. It goes high one edge after any status bit is set with its mask bit at 0, and it goes low one edge after no such bit remains.
- R9: Reads of any other offset in either window return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | Window select: 0 = port registers, 1 = interrupt registers |
| req_ofs | input | 5 | Byte offset within the window |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, zero-extended |
| pin_in | input | NUM_LINES | Pin levels from the pads |
| pin_out | output | NUM_LINES | Output latch toward the pads |
| pin_oe | output | NUM_LINES | Output enable per line |
| irq_out | output | 1 | Combined interrupt toward the parent controller |

## Verification
The bench builds the controller with NUM_LINES=8 and keeps DATA_W=32. With eight lines, every line can be walked through both polarities, and each walk times the two-edge read latency and the three-edge status latency exactly. The small width also means the zero-extension of the upper read bits is checked on every read. Mask, clear-by-zero and the set-wins-over-clear case are driven on chosen lines while other lines hold latched status, so any bleed between lines shows up in the full-width reads.

// File: rtl/pio_lvlint_pkg.sv
package pio_lvlint_pkg;

  localparam int OFS_W = 5;

  // port window (req_win = 0)
  localparam logic [OFS_W-1:0] PW_DIR  = 5'h04;
  localparam logic [OFS_W-1:0] PW_DATA = 5'h08;
  localparam logic [OFS_W-1:0] PW_POL  = 5'h0C;
  localparam logic [OFS_W-1:0] PW_STAT = 5'h10;

  // interrupt window (req_win = 1)
  localparam logic [OFS_W-1:0] IW_PEND = 5'h00;
  localparam logic [OFS_W-1:0] IW_MASK = 5'h08;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_DATA, SEL_POL, SEL_STAT, SEL_PEND, SEL_MASK
  } pio_sel_e;

  function automatic pio_sel_e pio_decode(input logic win, input logic [OFS_W-1:0] ofs);
    pio_sel_e s;
    s = SEL_NONE;
    if (!win) begin
      case (ofs)
        PW_DIR:  s = SEL_DIR;
        PW_DATA: s = SEL_DATA;
        PW_POL:  s = SEL_POL;
        PW_STAT: s = SEL_STAT;
        default: s = SEL_NONE;
      endcase
    end else begin
      case (ofs)
        IW_PEND: s = SEL_PEND;
        IW_MASK: s = SEL_MASK;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_data,
  input  logic         wr_pol,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] sync_in,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] data_rd
);
  // per-line pick between driven value and sampled pin
  function automatic logic [N-1:0] line_view(input logic [N-1:0] dir,
                                             input logic [N-1:0] drv,
                                             input logic [N-1:0] smp);
    return (dir & drv) | (~dir & smp);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      pol_q <= '0;
    end else begin
      if (wr_dir)  dir_q <= wdata;
      if (wr_data) out_q <= wdata;
      if (wr_pol)  pol_q <= wdata;
    end
  end

  assign data_rd = line_view(dir_q, out_q, sync_in);
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] pol,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] hit,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  // a line is active when its sampled level equals its polarity bit
  function automatic logic [N-1:0] level_hit(input logic [N-1:0] lvl,
                                             input logic [N-1:0] p);
    return ~(lvl ^ p);
  endfunction

  function automatic logic any_open(input logic [N-1:0] st,
                                    input logic [N-1:0] m);
    return |(st & ~m);
  endfunction

  logic [N-1:0] keep;

  assign hit  = level_hit(sync_in, pol);
  assign keep = wr_stat ? wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & keep) | hit;
      if (wr_mask) mask_q <= wdata;
      irq_q <= any_open(status_q, mask_q);
    end
  end
endmodule

// File: rtl/pio_lvlint_ctrl.sv
module pio_lvlint_ctrl
  import pio_lvlint_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_win,
  input  logic [OFS_W-1:0]     req_ofs,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq_out
);
  localparam int N = NUM_LINES;

  pio_sel_e     sel;
  logic         wr_en, rd_en;
  logic         dir_wr, data_wr, pol_wr, stat_wr, mask_wr;
  logic [N-1:0] wd;
  logic [N-1:0] sync_lvl;
  logic [N-1:0] dir_vec, out_vec, pol_vec, data_view;
  logic [N-1:0] hit_vec, status_vec, mask_vec;
  logic [N-1:0] rd_sel;

  assign sel     = pio_decode(req_win, req_ofs);
  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign dir_wr  = wr_en & (sel == SEL_DIR);
  assign data_wr = wr_en & (sel == SEL_DATA);
  assign pol_wr  = wr_en & (sel == SEL_POL);
  assign stat_wr = wr_en & (sel == SEL_STAT);
  assign mask_wr = wr_en & (sel == SEL_MASK);
  assign wd      = req_wdata[N-1:0];

  pio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  pio_port_regs #(.N(N)) u_port (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(dir_wr), .wr_data(data_wr), .wr_pol(pol_wr),
    .wdata(wd), .sync_in(sync_lvl),
    .dir_q(dir_vec), .out_q(out_vec), .pol_q(pol_vec), .data_rd(data_view)
  );

  pio_irq_unit #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .sync_in(sync_lvl), .pol(pol_vec),
    .wr_stat(stat_wr), .wr_mask(mask_wr), .wdata(wd),
    .hit(hit_vec), .status_q(status_vec), .mask_q(mask_vec), .irq_q(irq_out)
  );

  always_comb begin
    case (sel)
      SEL_DIR:  rd_sel = dir_vec;
      SEL_DATA: rd_sel = data_view;
      SEL_POL:  rd_sel = pol_vec;
      SEL_STAT: rd_sel = status_vec;
      SEL_PEND: rd_sel = status_vec;
      SEL_MASK: rd_sel = mask_vec;
      default:  rd_sel = '0;
    endcase
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd_en) rsp_rdata[N-1:0] = rd_sel;
  end

  assign pin_out = out_vec;
  assign pin_oe  = dir_vec;
endmodule

// File: rtl/pio_lvlint_chk.sv
module pio_lvlint_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] status_vec,
  input logic [N-1:0] mask_vec,
  input logic         stat_wr,
  input logic         irq_out
);
  // R4: an active line has its status bit set on the next edge
  p_hit_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((status_vec & $past(hit_vec)) == $past(hit_vec)));

  // R5: without a status write, no status bit ever falls
  p_no_silent_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

  // R6: all-ones mask keeps the interrupt low on the next edge
  p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '1) |=> !irq_out);

  // R8: an unmasked pending bit raises the interrupt one edge later
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_vec & ~mask_vec) != '0) |=> irq_out);

  // R8: with nothing unmasked pending, the interrupt drops one edge later
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_vec & ~mask_vec) == '0) |=> !irq_out);
endmodule

bind pio_lvlint_ctrl pio_lvlint_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hit_vec(hit_vec), .status_vec(status_vec), .mask_vec(mask_vec),
  .stat_wr(stat_wr), .irq_out(irq_out)
);

// File: tb/pio_lvlint_ctrl_test.sv
module pio_lvlint_ctrl_test;
  localparam int LN = 8;
  localparam int DW = 32;
  localparam logic [LN-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [4:0]    req_ofs = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic [LN-1:0] pin_in = '1;
  logic [LN-1:0] pin_out, pin_oe;
  logic          irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio_lvlint_ctrl #(.NUM_LINES(LN), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_win(req_win), .req_ofs(req_ofs), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write: drive at a falling edge, commit on the rising edge, return at the next falling edge
  task automatic wr(input logic win, input logic [4:0] ofs, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_win = win; req_ofs = ofs; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  // read: combinational, called while clk is low
  task automatic rd(input logic win, input logic [4:0] ofs, output logic [DW-1:0] d);
    req_valid = 1; req_write = 0; req_win = win; req_ofs = ofs;
    #1 d = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] z(input logic [LN-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[LN-1:0] = v;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [LN-1:0] inact, one;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(0, 5'h04, v); check("R1 dir", v, 0);
    rd(0, 5'h08, v); check("R1 data pins high", v, z(ALL));
    rd(0, 5'h0C, v); check("R1 pol", v, 0);
    rd(0, 5'h10, v); check("R1 status", v, 0);
    rd(1, 5'h08, v); check("R1 mask", v, z(ALL));
    rd(1, 5'h00, v); check("R1 pend", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);
    check("R1 pin_oe", z(pin_oe), 0);
    check("R1 pin_out", z(pin_out), 0);

    // R4/R3/R7: per-line, per-polarity sweep with exact latency
    for (int p = 0; p < 2; p++) begin
      wr(0, 5'h0C, p ? z(ALL) : 0);
      inact = p ? '0 : ALL;
      for (int i = 0; i < LN; i++) begin
        one = LN'(1) << i;
        @(negedge clk); pin_in = inact;
        idle(4);
        wr(0, 5'h10, 0);
        rd(0, 5'h10, v); check("R5 cleared before line test", v, 0);
        @(negedge clk); pin_in = inact ^ one;
        idle(2);
        rd(0, 5'h08, v); check("R3 input seen after two edges", v, z(inact ^ one));
        rd(0, 5'h10, v); check("R4 status not yet set", v, 0);
        idle(1);
        rd(0, 5'h10, v); check("R4 status set third edge", v, z(one));
        rd(1, 5'h00, v); check("R7 pend mirrors status", v, z(one));
        check("R6 masked irq low", {31'b0, irq_out}, 0);
        @(negedge clk); pin_in = inact;
        idle(4);
        rd(0, 5'h10, v); check("R4 status latched", v, z(one));
        wr(0, 5'h10, z(~one));
        rd(0, 5'h10, v); check("R5 one-hot complement clears", v, 0);
      end
    end

    // back to active-low, pins idle high
    wr(0, 5'h0C, 0);
    @(negedge clk); pin_in = ALL;
    idle(4);
    wr(0, 5'h10, 0);

    // R5: set wins over clear
    @(negedge clk); pin_in = ALL & ~LN'(1);
    idle(4);
    wr(0, 5'h10, 0);
    rd(0, 5'h10, v); check("R5 set beats clear", v, 1);
    @(negedge clk); pin_in = ALL;
    idle(4);
    wr(0, 5'h10, 0);
    rd(0, 5'h10, v); check("R5 clear after release", v, 0);

    // R5: ones leave bits alone
    @(negedge clk); pin_in = ALL & ~LN'(6);
    idle(4);
    @(negedge clk); pin_in = ALL;
    idle(4);
    rd(0, 5'h10, v); check("R5 two latched", v, 6);
    wr(0, 5'h10, z(~LN'(2)));
    rd(0, 5'h10, v); check("R5 only zero bit cleared", v, 4);
    wr(0, 5'h10, z(ALL));
    rd(0, 5'h10, v); check("R5 all ones keeps", v, 4);
    wr(0, 5'h10, 0);

    // R6/R8: mask and interrupt timing on line 3
    @(negedge clk); pin_in = ALL & ~LN'(8);
    idle(4);
    @(negedge clk); pin_in = ALL;
    idle(4);
    check("R6 all masked", {31'b0, irq_out}, 0);
    wr(1, 5'h08, z(~LN'(1)));
    idle(2);
    check("R6 other line unmasked stays low", {31'b0, irq_out}, 0);
    wr(1, 5'h08, z(~LN'(8)));
    check("R8 irq not yet after unmask", {31'b0, irq_out}, 0);
    idle(1);
    check("R8 irq one edge later", {31'b0, irq_out}, 1);
    wr(1, 5'h08, z(ALL));
    check("R8 irq holds one edge", {31'b0, irq_out}, 1);
    idle(1);
    check("R6 mask all drops irq", {31'b0, irq_out}, 0);
    wr(1, 5'h08, z(~LN'(8)));
    idle(1);
    check("R8 irq back", {31'b0, irq_out}, 1);
    wr(0, 5'h10, 0);
    check("R8 irq holds after clear", {31'b0, irq_out}, 1);
    idle(1);
    check("R8 irq low after clear", {31'b0, irq_out}, 0);

    // R7: pending ignores writes
    @(negedge clk); pin_in = ALL & ~LN'(16);
    idle(4);
    @(negedge clk); pin_in = ALL;
    idle(2);
    wr(1, 5'h00, 0);
    rd(1, 5'h00, v); check("R7 pend write ignored", v, 16);
    wr(0, 5'h10, 0);

    // R2/R3: direction and mixed data read over several pin patterns
    wr(0, 5'h04, 32'hA5);
    wr(0, 5'h08, 32'h3C);
    check("R2 pin_oe", z(pin_oe), 32'hA5);
    check("R2 pin_out", z(pin_out), 32'h3C);
    rd(0, 5'h04, v); check("R2 dir readback", v, 32'hA5);
    for (int k = 0; k < 4; k++) begin
      logic [LN-1:0] pv;
      pv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'hC3;
      @(negedge clk); pin_in = pv;
      idle(2);
      rd(0, 5'h08, v);
      check("R3 mixed data read", v, z((8'hA5 & 8'h3C) | (~8'hA5 & pv)));
    end
    @(negedge clk); pin_in = ALL;
    idle(4);
    wr(0, 5'h10, 0);

    // R9: unmapped offsets
    rd(0, 5'h00, v); check("R9 port 0x00 reads zero", v, 0);
    rd(0, 5'h14, v); check("R9 port 0x14 reads zero", v, 0);
    rd(1, 5'h04, v); check("R9 irq 0x04 reads zero", v, 0);
    rd(1, 5'h10, v); check("R9 irq 0x10 reads zero", v, 0);
    wr(0, 5'h00, 0);
    wr(0, 5'h14, 32'hFF);
    wr(1, 5'h04, 0);
    wr(1, 5'h0C, 0);
    wr(1, 5'h10, 0);
    rd(0, 5'h04, v); check("R9 dir unchanged", v, 32'hA5);
    rd(0, 5'h08, v); check("R9 data unchanged", v, z((8'hA5 & 8'h3C) | (~8'hA5 & ALL)));
    rd(0, 5'h0C, v); check("R9 pol unchanged", v, 0);
    rd(1, 5'h08, v); check("R9 mask unchanged", v, z(~LN'(8)));
    rd(0, 5'h10, v); check("R9 status unchanged", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule